// File: doc/BRIEF.md
# Polyphase 9/7 Wavelet Analysis Stage

This block performs one level of a one-dimensional forward wavelet transform with the biorthogonal 9/7 filter pair. A frame of N samples arrives as (even, odd) pairs. Once the whole frame is held, two distributed-arithmetic units run in parallel. One unit serves the even input phase and the other serves the odd phase. Each unit owns lookup tables for its half of the low-pass and high-pass taps. The two partial sums are added, scaled back by 1/256 with rounding, and written out.

Each pair of input samples yields one approximation and one detail coefficient. They appear together on two write ports. The approximations fill output addresses 0 to N/2-1 and the details fill N/2 to N-1. Samples beyond either end of the frame are taken by mirror reflection about the edge sample. A start pulse opens every frame and abandons any work still in flight.

Top module: `pdwt_analysis`

## Requirements
- R1: While reset is held, in_ready, out_valid and done are all low.
- R2: In the cycle after a start pulse, in_ready is high. It drops after exactly N/2 pairs have been taken (in_valid and in_ready both high at a clock edge). Pair p stores in_even as sample 2p and in_odd as sample 2p+1.
- R3: Approximation k equals (S + 128) >>> 8. Here S = 154·x[2k] + 68·(x[2k-1]+x[2k+1]) − 20·(x[2k-2]+x[2k+2]) − 4·(x[2k-3]+x[2k+3]) + 7·(x[2k-4]+x[2k+4]). The result is given as a two's-complement value of W+2 bits.
- R4: Detail k equals (D + 128) >>> 8. Here D = 285·x[2k+1] − 151·(x[2k]+x[2k+2]) − 15·(x[2k-1]+x[2k+3]) + 23·(x[2k-2]+x[2k+4]). The result has the same format as the approximation.
- R5: A sample index i < 0 reads x[−i], and an index i ≥ N reads x[2N−2−i].
- R6: A frame gives exactly N/2 out_valid cycles with k rising from 0. Each carries out_lo_addr = k and out_hi_addr = N/2 + k.
- R7: done is high for one cycle, the cycle right after the last out_valid of a frame.
- R8: in_valid and the input data have no effect while in_ready is low.
- R9: A start pulse during loading or computing abandons the current frame. None of that frame's outputs or done appear, and the next frame is computed from fresh samples.
- R10: Consecutive outputs of a frame are spaced W+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a new frame |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Stage takes pairs |
| in_even | input | W | Even-indexed sample, two's complement |
| in_odd | input | W | Odd-indexed sample, two's complement |
| out_valid | output | 1 | Output pair valid this cycle |
| out_lo_addr | output | log2(N) | Approximation address |
| out_lo_data | output | W+2 | Approximation value |
| out_hi_addr | output | log2(N) | Detail address |
| out_hi_data | output | W+2 | Detail value |
| done | output | 1 | Frame finished |

## Verification
A ramp and a constant frame test the low-pass and high-pass sums. On smooth input the approximation follows the input while the detail stays near zero, so a sign error or a swapped coefficient stands out. Single impulses at the first and the last sample touch only a few outputs, and their values show whether each mirror reflection lands on the correct index. An alternating full-scale pattern and extreme values push the high-pass gain and the output width, catching lost MSB weighting in the bit-serial sum. A pseudo-random frame mixes every tap, and restarts during loading and computing show that an abandoned frame leaves no trace.

// File: rtl/pdwt_pkg.sv
package pdwt_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CALC, ST_FIN} pdwt_state_e;

    localparam int EVEN_TAPS = 5;
    localparam int ODD_TAPS  = 4;

    // even window j holds x[2k-4+2j]; odd window j holds x[2k-3+2j]
    function automatic int tap_coef(input bit odd_ph, input bit hi_band, input int j);
        int c;
        c = 0;
        case ({odd_ph, hi_band})
            2'b00: case (j) 0, 4: c = 7;   1, 3: c = -20;  2: c = 154; default: c = 0; endcase
            2'b01: case (j) 1, 4: c = 23;  2, 3: c = -151; default: c = 0; endcase
            2'b10: case (j) 0, 3: c = -4;  1, 2: c = 68;   default: c = 0; endcase
            default: case (j) 1, 3: c = -15; 2: c = 285;   default: c = 0; endcase
        endcase
        return c;
    endfunction

    function automatic int lut_sum(input bit odd_ph, input bit hi_band, input int addr, input int taps);
        int s;
        s = 0;
        for (int t = 0; t < taps; t++)
            if (addr[t]) s += tap_coef(odd_ph, hi_band, t);
        return s;
    endfunction

    function automatic int mirror(input int idx, input int n);
        if (idx < 0)  return -idx;
        if (idx >= n) return 2 * n - 2 - idx;
        return idx;
    endfunction

endpackage

// File: rtl/pdwt_sample_store.sv
module pdwt_sample_store #(
    parameter int W = 8,
    parameter int N = 16,
    localparam int NP = N / 2,
    localparam int PB = (NP > 1) ? $clog2(NP) : 1,
    localparam int AB = $clog2(N)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [PB-1:0]                         wr_pair,
    input  logic [W-1:0]                          wr_even,
    input  logic [W-1:0]                          wr_odd,
    input  logic [PB-1:0]                         rd_ctr,
    output logic [pdwt_pkg::EVEN_TAPS-1:0][W-1:0] even_win,
    output logic [pdwt_pkg::ODD_TAPS-1:0][W-1:0]  odd_win
);
    logic [N-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[{wr_pair, 1'b0}] = wr_even;
            mem_d[{wr_pair, 1'b1}] = wr_odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // R5: reads past either edge are reflected about the edge sample
    always_comb begin
        for (int j = 0; j < pdwt_pkg::EVEN_TAPS; j++)
            even_win[j] = mem_q[AB'(pdwt_pkg::mirror(2 * int'(rd_ctr) - 4 + 2 * j, N))];
        for (int j = 0; j < pdwt_pkg::ODD_TAPS; j++)
            odd_win[j] = mem_q[AB'(pdwt_pkg::mirror(2 * int'(rd_ctr) - 3 + 2 * j, N))];
    end

    // R2
    pair_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[{$past(wr_pair), 1'b0}] == $past(wr_even));

endmodule

// File: rtl/pdwt_da_unit.sv
module pdwt_da_unit #(
    parameter int W    = 8,
    parameter int TAPS = 5,
    parameter bit ODD  = 1'b0,
    parameter int AW   = 20,
    localparam int DEPTH = 1 << TAPS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       load,
    input  logic                       step,
    input  logic                       first,
    input  logic [TAPS-1:0][W-1:0]     win,
    output logic signed [AW-1:0]       acc_lo,
    output logic signed [AW-1:0]       acc_hi
);
    typedef struct packed {
        logic [TAPS-1:0][W-1:0] sh;
        logic signed [AW-1:0]   lo;
        logic signed [AW-1:0]   hi;
    } da_t;

    da_t s_d, s_q;
    logic signed [AW-1:0] rom_lo [DEPTH];
    logic signed [AW-1:0] rom_hi [DEPTH];
    logic [TAPS-1:0]      slice;

    for (genvar a = 0; a < DEPTH; a++) begin : g_rom
        assign rom_lo[a] = AW'(pdwt_pkg::lut_sum(ODD, 1'b0, a, TAPS));
        assign rom_hi[a] = AW'(pdwt_pkg::lut_sum(ODD, 1'b1, a, TAPS));
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_slice
        assign slice[t] = s_q.sh[t][W-1];
    end

    // MSB first: the sign-bit slice carries negative weight
    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (load) begin
            s_d.sh = win;
            s_d.lo = '0;
            s_d.hi = '0;
        end else if (step) begin
            for (int t = 0; t < TAPS; t++) s_d.sh[t] = s_q.sh[t] << 1;
            s_d.lo = (s_q.lo <<< 1) + (first ? -rom_lo[slice] : rom_lo[slice]);
            s_d.hi = (s_q.hi <<< 1) + (first ? -rom_hi[slice] : rom_hi[slice]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_lo = s_q.lo;
    assign acc_hi = s_q.hi;

    // R3
    acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (acc_lo == '0 && acc_hi == '0));

endmodule

// File: rtl/pdwt_analysis.sv
module pdwt_analysis #(
    parameter int W = 8,
    parameter int N = 16,
    localparam int NP = N / 2,
    localparam int PB = (NP > 1) ? $clog2(NP) : 1,
    localparam int AB = $clog2(N),
    localparam int OW = W + 2,
    localparam int AW = W + 12,
    localparam int CW = $clog2(W + 2) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_even,
    input  logic [W-1:0]  in_odd,
    output logic          out_valid,
    output logic [AB-1:0] out_lo_addr,
    output logic [OW-1:0] out_lo_data,
    output logic [AB-1:0] out_hi_addr,
    output logic [OW-1:0] out_hi_data,
    output logic          done
);
    import pdwt_pkg::*;

    typedef struct packed {
        pdwt_state_e   st;
        logic [PB-1:0] pair;
        logic [PB-1:0] k;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t s_d, s_q;

    logic accept, da_load, da_step, da_first;
    logic [EVEN_TAPS-1:0][W-1:0] even_win;
    logic [ODD_TAPS-1:0][W-1:0]  odd_win;
    logic signed [AW-1:0] e_lo, e_hi, o_lo, o_hi, sum_lo, sum_hi;

    assign in_ready = (s_q.st == ST_LOAD);
    assign accept   = in_valid && in_ready;
    assign da_load  = (s_q.st == ST_CALC) && (s_q.cnt == '0);
    assign da_step  = (s_q.st == ST_CALC) && (s_q.cnt != '0) && (s_q.cnt <= CW'(W));
    assign da_first = (s_q.cnt == CW'(1));
    assign out_valid = (s_q.st == ST_CALC) && (s_q.cnt == CW'(W + 1));
    assign done      = (s_q.st == ST_FIN);

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.st   = ST_LOAD;
            s_d.pair = '0;
            s_d.k    = '0;
            s_d.cnt  = '0;
        end else begin
            case (s_q.st)
                ST_LOAD: if (accept) begin
                    if (s_q.pair == PB'(NP - 1)) begin
                        s_d.st  = ST_CALC;
                        s_d.k   = '0;
                        s_d.cnt = '0;
                    end else begin
                        s_d.pair = s_q.pair + 1'b1;
                    end
                end
                ST_CALC: if (out_valid) begin
                    s_d.cnt = '0;
                    if (s_q.k == PB'(NP - 1)) s_d.st = ST_FIN;
                    else                      s_d.k  = s_q.k + 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
                ST_FIN:  s_d.st = ST_IDLE;
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, pair: '0, k: '0, cnt: '0};
        else        s_q <= s_d;
    end

    pdwt_sample_store #(.W(W), .N(N)) u_store (
        .clk, .rst_n,
        .wr_en(accept), .wr_pair(s_q.pair), .wr_even(in_even), .wr_odd(in_odd),
        .rd_ctr(s_q.k), .even_win, .odd_win
    );

    pdwt_da_unit #(.W(W), .TAPS(EVEN_TAPS), .ODD(1'b0), .AW(AW)) u_da_even (
        .clk, .rst_n, .clear(start), .load(da_load), .step(da_step), .first(da_first),
        .win(even_win), .acc_lo(e_lo), .acc_hi(e_hi)
    );

    pdwt_da_unit #(.W(W), .TAPS(ODD_TAPS), .ODD(1'b1), .AW(AW)) u_da_odd (
        .clk, .rst_n, .clear(start), .load(da_load), .step(da_step), .first(da_first),
        .win(odd_win), .acc_lo(o_lo), .acc_hi(o_hi)
    );

    assign sum_lo = e_lo + o_lo + AW'(128);
    assign sum_hi = e_hi + o_hi + AW'(128);
    assign out_lo_data = OW'(sum_lo >>> 8);
    assign out_hi_data = OW'(sum_hi >>> 8);
    assign out_lo_addr = AB'(s_q.k);
    assign out_hi_addr = AB'(s_q.k) + AB'(NP);

    // R7
    done_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid));

    // R10
    emit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R6
    lo_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lo_addr < AB'(NP)));

    // R9
    ready_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(start));

endmodule

// File: tb/test_pdwt_analysis.sv
module test_pdwt_analysis;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int N  = 16;
    localparam int NP = N / 2;
    localparam int AB = $clog2(N);
    localparam int OW = W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [W-1:0] in_even = '0;
    logic [W-1:0] in_odd = '0;
    logic out_valid;
    logic [AB-1:0] out_lo_addr, out_hi_addr;
    logic [OW-1:0] out_lo_data, out_hi_data;
    logic done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pdwt_analysis #(.W(W), .N(N)) i_pdwt_analysis (
        .clk, .rst_n, .start, .in_valid, .in_ready, .in_even, .in_odd,
        .out_valid, .out_lo_addr, .out_lo_data, .out_hi_addr, .out_hi_data, .done
    );

    typedef struct { int k; int lo; int hi; } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_fail = 0;
    int done_cnt = 0, ncyc = 0, last_cyc = 0;
    bit prev_valid = 0;
    int x[N];

    task automatic chk(string req, int act, int expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int xs(int i);
        if (i < 0) return x[-i];
        if (i >= N) return x[2 * N - 2 - i];
        return x[i];
    endfunction

    task automatic push_expected();
        for (int k = 0; k < NP; k++) begin
            exp_t e;
            int s, d;
            int c;
            c = 2 * k;
            s = 154 * xs(c) + 68 * (xs(c-1) + xs(c+1)) - 20 * (xs(c-2) + xs(c+2))
                - 4 * (xs(c-3) + xs(c+3)) + 7 * (xs(c-4) + xs(c+4));
            d = 285 * xs(c+1) - 151 * (xs(c) + xs(c+2)) - 15 * (xs(c-1) + xs(c+3))
                + 23 * (xs(c-2) + xs(c+4));
            e.k = k; e.lo = (s + 128) >>> 8; e.hi = (d + 128) >>> 8;
            sb.push_back(e);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        ncyc++;
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R6 lo addr", int'(out_lo_addr), e.k);
                chk("R6 hi addr", int'(out_hi_addr), NP + e.k);
                chk("R3 approximation", int'($signed(out_lo_data)), e.lo);
                chk("R4 detail", int'($signed(out_hi_data)), e.hi);
                if (e.k > 0) chk("R10 spacing", ncyc - last_cyc, W + 2);
            end
            last_cyc = ncyc;
        end
        if (rst_n && done) begin
            done_cnt++;
            chk("R7 done after last output", int'(prev_valid), 1);
        end
        prev_valid = out_valid;
    end

    task automatic send_pair(int e, int o);
        in_valid = 1'b1;
        in_even = e[W-1:0];
        in_odd = o[W-1:0];
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 ready after start", int'(in_ready), 1);
    endtask

    task automatic run_block(bit junk);
        int d0;
        int t;
        push_expected();
        pulse_start();
        for (int p = 0; p < NP; p++) send_pair(x[2*p], x[2*p+1]);
        chk("R2 ready drops after N/2 pairs", int'(in_ready), 0);
        // R8: while busy, offered pairs carry junk that must not alter results
        in_valid = junk;
        in_even = 8'h5A;
        in_odd = 8'hA5;
        d0 = done_cnt;
        t = 0;
        while (done_cnt == d0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk("R6 all outputs produced", sb.size(), 0);
        chk("R7 done seen once", done_cnt - d0, 1);
        in_valid = 1'b0;
        sb.delete();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        chk("R1 in_ready in reset", int'(in_ready), 0);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: offers with no frame open are ignored
        in_valid = 1'b1; in_even = 8'h11; in_odd = 8'h22;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 idle no ready", int'(in_ready), 0);
            chk("R8 idle no output", int'(out_valid), 0);
        end
        in_valid = 1'b0;

        for (int i = 0; i < N; i++) x[i] = 8 * i - 60;          // ramp
        run_block(1'b0);
        for (int i = 0; i < N; i++) x[i] = 100;                 // constant
        run_block(1'b1);
        for (int i = 0; i < N; i++) x[i] = (i == 0) ? 120 : 0;  // R5 left edge impulse
        run_block(1'b0);
        for (int i = 0; i < N; i++) x[i] = (i == N-1) ? -100 : 0; // R5 right edge impulse
        run_block(1'b1);
        for (int i = 0; i < N; i++) x[i] = (i % 2) ? -128 : 127; // alternating full scale
        run_block(1'b0);
        for (int i = 0; i < N; i++) x[i] = (i % 4 < 2) ? -128 : 127;
        run_block(1'b0);
        seed = 7;
        for (int i = 0; i < N; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            x[i] = ((seed >> 16) & 255) - 128;
        end
        run_block(1'b1);

        // R9: restart in the middle of loading
        begin
            int hold[N];
            hold = x;
            start = 1'b1; @(negedge clk); start = 1'b0;
            for (int p = 0; p < 3; p++) send_pair(-77, 55);
            in_valid = 1'b0;
            x = hold;
            run_block(1'b0);
            // R9: restart just after the frame starts computing
            start = 1'b1; @(negedge clk); start = 1'b0;
            for (int p = 0; p < NP; p++) send_pair(99, -99);
            in_valid = 1'b0;
            for (int i = 0; i < N; i++) x[i] = 3 * i - 20;
            run_block(1'b0);
        end

        repeat (3 * (W + 2)) @(negedge clk);
        chk("R9 no stray output", int'(out_valid), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule